// File: doc/BRIEF.md
# Transactional Read/Write Set Tracker

This block holds the tag-side metadata of a small private data cache that keeps speculative transactional updates local until the transaction ends. For every line it stores a coherence state and two membership flags: one marks the line as read by the current transaction and one marks it as written. Local load and store hits set these flags while the core is inside a transaction. Evictions and external snoops are checked against the flags, so a conflict or an overflow is detected at cache-line granularity as soon as it happens.

Two bulk operations end a transaction, and each takes one clock edge. Commit clears every flag and keeps the line states. Abort invalidates each line that is both modified and marked as written, which discards the speculative data, and then clears every flag. At both events the block reports how many lines were in each set. Abort can be requested explicitly or raised internally, and a two-bit cause says which. Data arrays, victim selection and the directory are not part of this block.

Top module: `txn_set_tracker`

## Requirements
- R1: After reset every line is invalid, no line is in either set, and `abortReq` and `countValid` are low. Line state codes are invalid=0, shared=1, exclusive=2, modified=3, and line i occupies bits [2i+1:2i] of `lineStates`.
- R2: A load hit with `inTxn` high marks the line as read, and a store hit with `inTxn` high marks it as written. A store hit on a non-invalid line makes that line modified whether or not `inTxn` is high.
- R3: Load and store hits with `inTxn` low mark no line in either set.
- R4: On a commit, one cycle later `countValid` is high for one cycle with `rdCount` and `wrCount` equal to the set sizes held before the commit, every flag is clear, and line states are unchanged.
- R5: On an explicit abort, one cycle later `abortReq` is high with `abortCause`=1, `countValid` reports the set sizes, every modified line that was in the write set is invalid, other lines keep their state, and every flag is clear. Cause codes: 0 none, 1 explicit, 2 size overflow, 3 memory conflict.
- R6: Evicting a line that is in either set raises an abort with cause 2. Evicting an unmarked line raises no abort. The evicted line becomes invalid in both cases.
- R7: A snoop write to a line in either set, or a snoop read of a line in the write set, raises an abort with cause 3. A snoop read of a line only in the read set raises no abort. A snoop write makes the line invalid; a snoop read turns a modified or exclusive line into shared.
- R8: A commit and an abort request in the same cycle act as an abort.
- R9: A fill installs the line as exclusive when `fillExcl` is high and as shared otherwise.
- R10: When several abort sources coincide, the reported cause is the highest of conflict (3), then size overflow (2), then explicit (1).
- R11: `abortReq` is never high in a cycle that follows one with no abort source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inTxn | input | 1 | Core is in transactional state |
| ldHit | input | 1 | Local load hit on line `accIdx` |
| stHit | input | 1 | Local store hit on line `accIdx` |
| accIdx | input | IDX_W | Line index of the local access |
| fillValid | input | 1 | Install line `fillIdx` |
| fillExcl | input | 1 | Fill grants exclusive (1) or shared (0) |
| fillIdx | input | IDX_W | Line index of the fill |
| evictValid | input | 1 | Line `evictIdx` is evicted locally |
| evictIdx | input | IDX_W | Line index of the eviction |
| snoopValid | input | 1 | External request to line `snoopIdx` |
| snoopWrite | input | 1 | Snoop seeks to modify (1) or read (0) |
| snoopIdx | input | IDX_W | Line index of the snoop |
| commitCmd | input | 1 | Commit the outer transaction |
| abortCmd | input | 1 | Explicit abort |
| abortReq | output | 1 | Abort taken in the previous cycle |
| abortCause | output | 2 | Cause code of that abort |
| lineStates | output | 2*NUM_LINES | Packed per-line coherence states |
| countValid | output | 1 | Set sizes valid (commit or abort) |
| rdCount | output | CNT_W | Read-set size at the event |
| wrCount | output | CNT_W | Write-set size at the event |

## Verification
Every line index is swept through each scenario, so a wrong index decode or a flag stuck on one line shows up as a wrong state or count on some other line. Mixed patterns of even-indexed loads and multiple-of-three stores give set sizes that differ from each other and from zero, separating read-set from write-set counting. Evictions and snoops are applied both to the marked line and to an unmarked neighbour, which separates a real conflict from a spurious one, and snoop reads are tried on read-only and written lines to tell the two conflict rules apart. Coinciding abort sources and a commit that meets an abort check the priority order.

// File: rtl/tst_pkg.sv
package tst_pkg;

  typedef enum logic [1:0] {
    LINE_I = 2'd0,
    LINE_S = 2'd1,
    LINE_E = 2'd2,
    LINE_M = 2'd3
  } lineState_t;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_EXPLICIT = 2'd1,
    CAUSE_SIZE     = 2'd2,
    CAUSE_CONFLICT = 2'd3
  } abortCause_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rollback;   // invalidate modified lines of the write set
    logic clearSets;  // clear every read/write flag
    logic snapshot;   // capture set sizes
  } trkStrobe_t;

endpackage

// File: rtl/tst_datapath.sv
module tst_datapath
  import tst_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int IDX_W     = 4,
  parameter int CNT_W     = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inTxn,
  input  logic                   ldHit,
  input  logic                   stHit,
  input  logic [IDX_W-1:0]       accIdx,
  input  logic                   fillValid,
  input  logic                   fillExcl,
  input  logic [IDX_W-1:0]       fillIdx,
  input  logic                   evictValid,
  input  logic [IDX_W-1:0]       evictIdx,
  input  logic                   snoopValid,
  input  logic                   snoopWrite,
  input  logic [IDX_W-1:0]       snoopIdx,
  input  trkStrobe_t             strobe,
  output logic                   evictMarked,
  output logic                   snoopOnRd,
  output logic                   snoopOnWr,
  output logic [2*NUM_LINES-1:0] lineStates,
  output logic [NUM_LINES-1:0]   rdSet,
  output logic [NUM_LINES-1:0]   wrSet,
  output logic [CNT_W-1:0]       rdCount,
  output logic [CNT_W-1:0]       wrCount
);

  function automatic logic [CNT_W-1:0] popCount(input logic [NUM_LINES-1:0] v);
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < NUM_LINES; k++) acc = acc + CNT_W'(v[k]);
    return acc;
  endfunction

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    lineState_t cur, nxt;
    logic rdBit, wrBit;
    logic accHere, fillHere, evictHere, snoopHere;

    assign accHere   = (accIdx   == IDX_W'(g));
    assign fillHere  = fillValid  && (fillIdx  == IDX_W'(g));
    assign evictHere = evictValid && (evictIdx == IDX_W'(g));
    assign snoopHere = snoopValid && (snoopIdx == IDX_W'(g));

    always_comb begin
      nxt = cur;
      if (fillHere) nxt = fillExcl ? LINE_E : LINE_S;
      if (stHit && accHere && cur != LINE_I) nxt = LINE_M;
      if (snoopHere) begin
        if (snoopWrite) nxt = LINE_I;
        else if (nxt == LINE_M || nxt == LINE_E) nxt = LINE_S;
      end
      if (evictHere) nxt = LINE_I;
      if (strobe.rollback && cur == LINE_M && wrBit) nxt = LINE_I;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cur   <= LINE_I;
        rdBit <= 1'b0;
        wrBit <= 1'b0;
      end else begin
        cur <= nxt;
        if (strobe.clearSets) begin
          rdBit <= 1'b0;
          wrBit <= 1'b0;
        end else begin
          if (inTxn && ldHit && accHere) rdBit <= 1'b1;
          if (inTxn && stHit && accHere) wrBit <= 1'b1;
        end
      end
    end

    assign rdSet[g]            = rdBit;
    assign wrSet[g]            = wrBit;
    assign lineStates[2*g +: 2] = cur;
  end

  assign evictMarked = rdSet[evictIdx] | wrSet[evictIdx];
  assign snoopOnRd   = rdSet[snoopIdx];
  assign snoopOnWr   = wrSet[snoopIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdCount <= '0;
      wrCount <= '0;
    end else if (strobe.snapshot) begin
      rdCount <= popCount(rdSet);
      wrCount <= popCount(wrSet);
    end
  end

endmodule

// File: rtl/tst_ctrl.sv
module tst_ctrl
  import tst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       commitCmd,
  input  logic       abortCmd,
  input  logic       evictValid,
  input  logic       evictMarked,
  input  logic       snoopValid,
  input  logic       snoopWrite,
  input  logic       snoopOnRd,
  input  logic       snoopOnWr,
  output trkStrobe_t strobe,
  output logic       abortReq,
  output logic [1:0] abortCause,
  output logic       countValid
);

  logic        conflictNow, sizeNow, abortNow, commitNow;
  abortCause_t causeNow;

  assign conflictNow = snoopValid && (snoopWrite ? (snoopOnRd | snoopOnWr) : snoopOnWr);
  assign sizeNow     = evictValid && evictMarked;
  assign abortNow    = conflictNow | sizeNow | abortCmd;
  assign commitNow   = commitCmd & ~abortNow;

  always_comb begin
    if (conflictNow)   causeNow = CAUSE_CONFLICT;
    else if (sizeNow)  causeNow = CAUSE_SIZE;
    else if (abortCmd) causeNow = CAUSE_EXPLICIT;
    else               causeNow = CAUSE_NONE;
  end

  always_comb begin
    strobe.rollback  = abortNow;
    strobe.clearSets = abortNow | commitNow;
    strobe.snapshot  = abortNow | commitNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      abortReq   <= 1'b0;
      abortCause <= CAUSE_NONE;
      countValid <= 1'b0;
    end else begin
      abortReq   <= abortNow;
      abortCause <= causeNow;
      countValid <= abortNow | commitNow;
    end
  end

endmodule

// File: rtl/txn_set_tracker.sv
module txn_set_tracker
  import tst_pkg::*;
#(
  parameter  int NUM_LINES = 16,
  localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int CNT_W     = $clog2(NUM_LINES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inTxn,
  input  logic                   ldHit,
  input  logic                   stHit,
  input  logic [IDX_W-1:0]       accIdx,
  input  logic                   fillValid,
  input  logic                   fillExcl,
  input  logic [IDX_W-1:0]       fillIdx,
  input  logic                   evictValid,
  input  logic [IDX_W-1:0]       evictIdx,
  input  logic                   snoopValid,
  input  logic                   snoopWrite,
  input  logic [IDX_W-1:0]       snoopIdx,
  input  logic                   commitCmd,
  input  logic                   abortCmd,
  output logic                   abortReq,
  output logic [1:0]             abortCause,
  output logic [2*NUM_LINES-1:0] lineStates,
  output logic                   countValid,
  output logic [CNT_W-1:0]       rdCount,
  output logic [CNT_W-1:0]       wrCount
);

  trkStrobe_t           strobe;
  logic                 evictMarked, snoopOnRd, snoopOnWr;
  logic [NUM_LINES-1:0] rdSet, wrSet;

  tst_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .commitCmd  (commitCmd),
    .abortCmd   (abortCmd),
    .evictValid (evictValid),
    .evictMarked(evictMarked),
    .snoopValid (snoopValid),
    .snoopWrite (snoopWrite),
    .snoopOnRd  (snoopOnRd),
    .snoopOnWr  (snoopOnWr),
    .strobe     (strobe),
    .abortReq   (abortReq),
    .abortCause (abortCause),
    .countValid (countValid)
  );

  tst_datapath #(
    .NUM_LINES(NUM_LINES),
    .IDX_W    (IDX_W),
    .CNT_W    (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .inTxn      (inTxn),
    .ldHit      (ldHit),
    .stHit      (stHit),
    .accIdx     (accIdx),
    .fillValid  (fillValid),
    .fillExcl   (fillExcl),
    .fillIdx    (fillIdx),
    .evictValid (evictValid),
    .evictIdx   (evictIdx),
    .snoopValid (snoopValid),
    .snoopWrite (snoopWrite),
    .snoopIdx   (snoopIdx),
    .strobe     (strobe),
    .evictMarked(evictMarked),
    .snoopOnRd  (snoopOnRd),
    .snoopOnWr  (snoopOnWr),
    .lineStates (lineStates),
    .rdSet      (rdSet),
    .wrSet      (wrSet),
    .rdCount    (rdCount),
    .wrCount    (wrCount)
  );

endmodule

// File: rtl/tst_checker.sv
module tst_checker #(
  parameter  int NUM_LINES = 16,
  localparam int CNT_W     = $clog2(NUM_LINES + 1)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   inTxn,
  input logic                   abortReq,
  input logic [1:0]             abortCause,
  input logic                   countValid,
  input logic [CNT_W-1:0]       rdCount,
  input logic [CNT_W-1:0]       wrCount,
  input logic [2*NUM_LINES-1:0] lineStates,
  input logic [NUM_LINES-1:0]   rdSet,
  input logic [NUM_LINES-1:0]   wrSet
);

  logic [NUM_LINES-1:0] modWrMask, liveMask;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      modWrMask[i] = (lineStates[2*i +: 2] == 2'd3) && wrSet[i];
      liveMask[i]  = (lineStates[2*i +: 2] != 2'd0);
    end
  end

  // R5: every abort carries a nonzero cause
  a_r5_cause_set: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |-> abortCause != 2'd0);

  // R5: every abort also reports the set sizes
  a_r5_abort_counts: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |-> countValid);

  // R4: after a commit or abort no flag remains
  a_r4_sets_cleared: assert property (@(posedge clk) disable iff (!rstN)
    countValid |-> (rdSet == '0 && wrSet == '0));

  // R5: speculatively modified lines are gone after an abort
  a_r5_rollback: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |-> (($past(modWrMask) & liveMask) == '0));

  // R3: outside a transaction no flag is newly set
  a_r3_no_growth: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inTxn) |-> ((rdSet & ~$past(rdSet)) == '0 && (wrSet & ~$past(wrSet)) == '0));

  // R4: reported sizes never exceed the line count
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    countValid |-> (rdCount <= CNT_W'(NUM_LINES) && wrCount <= CNT_W'(NUM_LINES)));

endmodule

bind txn_set_tracker tst_checker #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inTxn     (inTxn),
  .abortReq  (abortReq),
  .abortCause(abortCause),
  .countValid(countValid),
  .rdCount   (rdCount),
  .wrCount   (wrCount),
  .lineStates(lineStates),
  .rdSet     (rdSet),
  .wrSet     (wrSet)
);

// File: tb/txn_set_tracker_tb.sv
`timescale 1ns/1ps
module txn_set_tracker_tb;

  localparam int N = 16;
  localparam int IW = 4;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inTxn = 0, ldHit = 0, stHit = 0, fillValid = 0, fillExcl = 0;
  logic evictValid = 0, snoopValid = 0, snoopWrite = 0, commitCmd = 0, abortCmd = 0;
  logic [IW-1:0] accIdx = '0, fillIdx = '0, evictIdx = '0, snoopIdx = '0;
  logic abortReq, countValid;
  logic [1:0] abortCause;
  logic [2*N-1:0] lineStates;
  logic [CW-1:0] rdCount, wrCount;

  int nChecks = 0;
  int nFail = 0;

  // model state
  int mSt[N];
  bit mRd[N];
  bit mWr[N];

  always #10 clk = ~clk;

  txn_set_tracker #(.NUM_LINES(N)) u_dut (
    .clk(clk), .rstN(rstN), .inTxn(inTxn), .ldHit(ldHit), .stHit(stHit),
    .accIdx(accIdx), .fillValid(fillValid), .fillExcl(fillExcl), .fillIdx(fillIdx),
    .evictValid(evictValid), .evictIdx(evictIdx), .snoopValid(snoopValid),
    .snoopWrite(snoopWrite), .snoopIdx(snoopIdx), .commitCmd(commitCmd),
    .abortCmd(abortCmd), .abortReq(abortReq), .abortCause(abortCause),
    .lineStates(lineStates), .countValid(countValid), .rdCount(rdCount),
    .wrCount(wrCount)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2*N-1:0] expVec();
    logic [2*N-1:0] v;
    for (int i = 0; i < N; i++) v[2*i +: 2] = 2'(mSt[i]);
    return v;
  endfunction

  // one clock with the currently driven inputs, then compare
  task automatic cycle(input string req);
    bit conflict, size, abortNow, commitNow;
    int cause, rdN, wrN;
    int nst[N];
    conflict = snoopValid && (snoopWrite ? (mRd[snoopIdx] || mWr[snoopIdx]) : mWr[snoopIdx]);
    size = evictValid && (mRd[evictIdx] || mWr[evictIdx]);
    abortNow = conflict || size || abortCmd;
    commitNow = commitCmd && !abortNow;
    cause = conflict ? 3 : size ? 2 : abortCmd ? 1 : 0;
    rdN = 0; wrN = 0;
    for (int i = 0; i < N; i++) begin
      rdN += mRd[i]; wrN += mWr[i];
      nst[i] = mSt[i];
      if (fillValid && fillIdx == IW'(i)) nst[i] = fillExcl ? 2 : 1;
      if (stHit && accIdx == IW'(i) && mSt[i] != 0) nst[i] = 3;
      if (snoopValid && snoopIdx == IW'(i)) begin
        if (snoopWrite) nst[i] = 0;
        else if (nst[i] >= 2) nst[i] = 1;
      end
      if (evictValid && evictIdx == IW'(i)) nst[i] = 0;
      if (abortNow && mSt[i] == 3 && mWr[i]) nst[i] = 0;
    end
    for (int i = 0; i < N; i++) begin
      mSt[i] = nst[i];
      if (abortNow || commitNow) begin
        mRd[i] = 0; mWr[i] = 0;
      end else if (inTxn && accIdx == IW'(i)) begin
        if (ldHit) mRd[i] = 1;
        if (stHit) mWr[i] = 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    ldHit = 0; stHit = 0; fillValid = 0; evictValid = 0; snoopValid = 0;
    commitCmd = 0; abortCmd = 0; inTxn = 0;
    check(lineStates == expVec(), {req, " states"}, lineStates, expVec());
    check(abortReq == abortNow, {req, " abortReq"}, abortReq, abortNow);
    if (abortNow) check(abortCause == 2'(cause), {req, " cause"}, abortCause, cause);
    check(countValid == (abortNow || commitNow), {req, " countValid"}, countValid, abortNow || commitNow);
    if (abortNow || commitNow) begin
      check(rdCount == CW'(rdN), {req, " rdCount"}, rdCount, rdN);
      check(wrCount == CW'(wrN), {req, " wrCount"}, wrCount, wrN);
    end
  endtask

  task automatic doFill(input int i, input bit ex);
    fillValid = 1; fillIdx = IW'(i); fillExcl = ex; cycle("R9 fill");
  endtask
  task automatic doLoad(input int i, input bit t, input string req);
    ldHit = 1; accIdx = IW'(i); inTxn = t; cycle(req);
  endtask
  task automatic doStore(input int i, input bit t, input string req);
    stHit = 1; accIdx = IW'(i); inTxn = t; cycle(req);
  endtask
  task automatic doEvict(input int i);
    evictValid = 1; evictIdx = IW'(i); cycle("R6 evict");
  endtask
  task automatic doSnoop(input int i, input bit w);
    snoopValid = 1; snoopIdx = IW'(i); snoopWrite = w; cycle("R7 snoop");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin mSt[i] = 0; mRd[i] = 0; mWr[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(lineStates == '0, "R1 states", lineStates, 0);
    check(abortReq == 1'b0, "R1 abortReq", abortReq, 0);
    check(countValid == 1'b0, "R1 countValid", countValid, 0);

    // R9 fills
    for (int i = 0; i < N; i++) doFill(i, (i % 2) == 0);

    // R2 / R4 mixed transactional accesses then commit
    for (int i = 0; i < N; i++) begin
      if (i % 2 == 0) doLoad(i, 1, "R2 load");
      if (i % 3 == 0) doStore(i, 1, "R2 store");
    end
    commitCmd = 1; cycle("R4 commit");

    // R3 non-transactional accesses mark nothing
    for (int i = 0; i < N; i++) begin
      doLoad(i, 0, "R3 load");
      doStore(i, 0, "R3 store");
    end
    commitCmd = 1; cycle("R3 commit");

    // R5 explicit abort per line
    for (int i = 0; i < N; i++) begin
      doFill(i, 1);
      doStore(i, 1, "R5 store");
      doLoad((i + 1) % N, 1, "R5 load");
      abortCmd = 1; cycle("R5 abort");
    end

    // R6 evictions
    for (int i = 0; i < N; i++) begin
      doFill(i, 0);
      doLoad(i, 1, "R6 load");
      doEvict((i + 5) % N);
      doEvict(i);
    end

    // R7 snoops
    for (int i = 0; i < N; i++) begin
      doFill(i, 1);
      doLoad(i, 1, "R7 load");
      doSnoop(i, 0);
      doSnoop(i, 1);
      doFill(i, 0);
      doStore(i, 1, "R7 store");
      doSnoop(i, 0);
      doFill((i + 3) % N, 1);
      doSnoop((i + 3) % N, 1);
    end

    // R8 commit and abort together
    doFill(0, 1);
    doStore(0, 1, "R8 store");
    commitCmd = 1; abortCmd = 1; cycle("R8 commit+abort");

    // R10 priority: conflict over size over explicit
    doFill(1, 1); doFill(2, 1);
    doLoad(1, 1, "R10 load"); doLoad(2, 1, "R10 load");
    snoopValid = 1; snoopIdx = 1; snoopWrite = 1;
    evictValid = 1; evictIdx = 2; abortCmd = 1;
    cycle("R10 conflict first");
    doFill(2, 1);
    doLoad(2, 1, "R10 load");
    evictValid = 1; evictIdx = 2; abortCmd = 1;
    cycle("R10 size over explicit");

    // R11 idle cycles raise nothing
    for (int k = 0; k < 4; k++) cycle("R11 idle");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule